// File: doc/BRIEF.md
# Circular Reorder Buffer

This block keeps in-flight micro-operations in program order between issue and retirement. Each cycle the issue stage may request several new slots at once. The buffer accepts the request only when every requested slot is free, and it returns the slot index for each lane. That slot index is the tag the execution side later attaches to the result it broadcasts. A single result port takes a tagged value and marks the matching live slot complete. It also records whether the slot, if it holds a branch, was mispredicted.

Slots are drained from the oldest end. Up to a fixed number of consecutive completed slots leave per cycle, and draining halts at the first slot that has not completed. A draining slot produces an architectural register write or a store request, chosen by its destination kind. When a mispredicted branch drains, it is the last slot to leave that cycle. Every younger slot is then discarded, and the next allocation continues from the slot just after the branch. The restarted fetch, the execution units and the data cache sit outside this block.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `cm_valid` is 0, `flush_o` is 0, and a request of `ALLOC_W` slots is accepted.
- R2: Lane j of an allocation receives the tag (tail + j) modulo `DEPTH`, and the tag wraps from `DEPTH`-1 to 0. A request of n slots is accepted (`alloc_ready` high) only when at least n slots are free. A refused request allocates nothing.
- R3: With all `DEPTH` slots occupied, any request of one or more slots is refused, and a request of zero slots still shows `alloc_ready` high.
- R4: A result write whose tag names a live slot marks that slot complete and stores its value. A result write to a tag with no live slot has no effect, so a slot allocated there later stays incomplete.
- R5: Commit lane k presents the slot at head + k. At most `RETIRE_W` slots drain per cycle, in order. Draining stops at the first incomplete slot, so completed younger slots wait behind it.
- R6: Operation encoding is 0 = register op, 1 = store, 2 = branch. Destination encoding is 0 = none, 1 = register, 2 = memory. A draining slot raises `cm_reg_we` for destination register, raises `cm_store` for destination memory, raises neither for none, and carries its register number, value and tag.
- R7: Slots that drain on a clock edge become free from that edge, and are not available to an allocation in the same cycle.
- R8: A completed branch marked mispredicted drains with `flush_o` high. No lane after it is valid in that cycle. All younger slots are discarded, and the next allocation starts at the tag after the branch.
- R9: A branch completed without misprediction drains like any other slot. A misprediction mark on a non-branch slot is ignored.
- R10: In a cycle with `flush_o` high, every allocation request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | $clog2(ALLOC_W+1) | Number of slots requested this cycle |
| alloc_op | input | 2*ALLOC_W | Operation kind per lane |
| alloc_dst | input | 2*ALLOC_W | Destination kind per lane |
| alloc_areg | input | AREG_W*ALLOC_W | Architectural register number per lane |
| alloc_ready | output | 1 | Request is accepted this cycle |
| alloc_tag | output | IDX_W*ALLOC_W | Tag given to each lane |
| wb_valid | input | 1 | Result write present |
| wb_tag | input | IDX_W | Tag of the result |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Branch outcome differs from prediction |
| cm_valid | output | RETIRE_W | Lane drains a slot this cycle |
| cm_reg_we | output | RETIRE_W | Lane writes an architectural register |
| cm_store | output | RETIRE_W | Lane performs a store |
| cm_areg | output | AREG_W*RETIRE_W | Register number per lane |
| cm_value | output | DATA_W*RETIRE_W | Value per lane |
| cm_tag | output | IDX_W*RETIRE_W | Tag per lane |
| flush_o | output | 1 | A mispredicted branch drains; younger slots discarded |

## Verification
The assertions assume the result side never presents a tag of `DEPTH` or above, and never writes the same live slot twice. They also assume a branch mark arrives together with its single result write. The directed stimulus uses only tags that were handed out by the buffer or that name a known free slot. It gives each live slot exactly one result write and keeps `alloc_cnt` within `ALLOC_W`. Under those inputs, occupancy follows allocations minus drains exactly, and a flush always leaves the buffer empty.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {OP_REG = 2'd0, OP_STORE = 2'd1, OP_BRANCH = 2'd2} op_kind_e;
   typedef enum logic [1:0] {DK_NONE = 2'd0, DK_REG = 2'd1, DK_MEM = 2'd2} dst_kind_e;

   // slot index advance with wrap; n is always below depth
   function automatic int unsigned wrap_add(input int unsigned idx, input int unsigned n,
                                            input int unsigned depth);
      int unsigned s;
      s = idx + n;
      return (s >= depth) ? s - depth : s;
   endfunction
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter int unsigned DEPTH    = 40,
   parameter int unsigned ALLOC_W  = 6,
   parameter int unsigned RETIRE_W = 3,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned AN_W  = $clog2(ALLOC_W + 1),
   localparam int unsigned RN_W  = $clog2(RETIRE_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AN_W-1:0]  alloc_n,
   input  logic [RN_W-1:0]  commit_n,
   input  logic             flush,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic [CNT_W-1:0] used_o,
   output logic [CNT_W-1:0] free_o
);
   // pointers carry a wrap bit above the slot index
   logic [IDX_W:0] head_q, tail_q;
   int unsigned    used_i;

   function automatic logic [IDX_W:0] step(input logic [IDX_W:0] p, input int unsigned n);
      int unsigned s;
      logic        w;
      s = 32'(p[IDX_W-1:0]) + n;
      w = p[IDX_W];
      if (s >= DEPTH) begin
         s = s - DEPTH;
         w = ~w;
      end
      return {w, s[IDX_W-1:0]};
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= step(head_q, 32'(commit_n));
         tail_q <= flush ? step(head_q, 32'(commit_n)) : step(tail_q, 32'(alloc_n));
      end
   end

   always_comb begin
      if (head_q[IDX_W] == tail_q[IDX_W])
         used_i = 32'(tail_q[IDX_W-1:0]) - 32'(head_q[IDX_W-1:0]);
      else
         used_i = DEPTH + 32'(tail_q[IDX_W-1:0]) - 32'(head_q[IDX_W-1:0]);
   end

   assign used_o   = CNT_W'(used_i);
   assign free_o   = CNT_W'(DEPTH - used_i);
   assign head_idx = head_q[IDX_W-1:0];
   assign tail_idx = tail_q[IDX_W-1:0];

   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (used_o == '0));

   // R7
   occupancy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (int'(used_o) == int'($past(used_o)) + int'($past(alloc_n)) - int'($past(commit_n))));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_n != '0) |-> (32'(alloc_n) <= 32'(free_o)));
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH    = 40,
   parameter int unsigned ALLOC_W  = 6,
   parameter int unsigned RETIRE_W = 3,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned AREG_W   = 5,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned SEL_W = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              al_we   [ALLOC_W],
   input  logic [IDX_W-1:0]  al_idx  [ALLOC_W],
   input  op_kind_e          al_op   [ALLOC_W],
   input  dst_kind_e         al_dst  [ALLOC_W],
   input  logic [AREG_W-1:0] al_areg [ALLOC_W],
   input  logic              wb_valid,
   input  logic [IDX_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_value,
   input  logic              wb_mp,
   input  logic              flush,
   input  logic              rt_en   [RETIRE_W],
   input  logic [IDX_W-1:0]  rd_idx  [RETIRE_W],
   output logic              rd_valid[RETIRE_W],
   output logic              rd_done [RETIRE_W],
   output logic              rd_mp   [RETIRE_W],
   output op_kind_e          rd_op   [RETIRE_W],
   output dst_kind_e         rd_dst  [RETIRE_W],
   output logic [AREG_W-1:0] rd_areg [RETIRE_W],
   output logic [DATA_W-1:0] rd_value[RETIRE_W]
);
   logic              valid_q [DEPTH];
   logic              done_q  [DEPTH];
   logic              mp_q    [DEPTH];
   op_kind_e          op_q    [DEPTH];
   dst_kind_e         dst_q   [DEPTH];
   logic [AREG_W-1:0] areg_q  [DEPTH];
   logic [DATA_W-1:0] value_q [DEPTH];

   logic              hit   [DEPTH];
   logic [SEL_W-1:0]  sel   [DEPTH];
   logic              rt_clr[DEPTH];

   always_comb begin
      for (int e = 0; e < int'(DEPTH); e++) begin
         hit[e]    = 1'b0;
         sel[e]    = '0;
         rt_clr[e] = 1'b0;
         for (int j = 0; j < int'(ALLOC_W); j++) begin
            if (al_we[j] && (al_idx[j] == IDX_W'(e))) begin
               hit[e] = 1'b1;
               sel[e] = SEL_W'(j);
            end
         end
         for (int k = 0; k < int'(RETIRE_W); k++)
            if (rt_en[k] && (rd_idx[k] == IDX_W'(e))) rt_clr[e] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < int'(DEPTH); e++) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            done_q[e]  <= 1'b0;
            mp_q[e]    <= 1'b0;
            op_q[e]    <= OP_REG;
            dst_q[e]   <= DK_NONE;
            areg_q[e]  <= '0;
            value_q[e] <= '0;
         end else if (flush) begin
            valid_q[e] <= 1'b0;
         end else if (hit[e]) begin
            valid_q[e] <= 1'b1;
            done_q[e]  <= 1'b0;
            mp_q[e]    <= 1'b0;
            op_q[e]    <= al_op[sel[e]];
            dst_q[e]   <= al_dst[sel[e]];
            areg_q[e]  <= al_areg[sel[e]];
         end else begin
            if (rt_clr[e]) valid_q[e] <= 1'b0;
            if (wb_valid && (wb_tag == IDX_W'(e)) && valid_q[e]) begin
               done_q[e]  <= 1'b1;
               mp_q[e]    <= wb_mp;
               value_q[e] <= wb_value;
            end
         end
      end
   end

   always_comb begin
      for (int k = 0; k < int'(RETIRE_W); k++) begin
         rd_valid[k] = valid_q[rd_idx[k]];
         rd_done[k]  = done_q[rd_idx[k]];
         rd_mp[k]    = mp_q[rd_idx[k]];
         rd_op[k]    = op_q[rd_idx[k]];
         rd_dst[k]   = dst_q[rd_idx[k]];
         rd_areg[k]  = areg_q[rd_idx[k]];
         rd_value[k] = value_q[rd_idx[k]];
      end
   end

   for (genvar e = 0; e < int'(DEPTH); e++) begin : g_slot_chk
      // R4
      wb_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wb_valid && (wb_tag == IDX_W'(e)) && valid_q[e] && !flush && !rt_clr[e])
         |=> (done_q[e] && (value_q[e] == $past(wb_value))));
   end
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH    = 40,
   parameter int unsigned RETIRE_W = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned RN_W  = $clog2(RETIRE_W + 1)
) (
   input  logic [CNT_W-1:0] used,
   input  logic             rd_valid[RETIRE_W],
   input  logic             rd_done [RETIRE_W],
   input  logic             rd_mp   [RETIRE_W],
   input  op_kind_e         rd_op   [RETIRE_W],
   output logic             rt_en   [RETIRE_W],
   output logic [RN_W-1:0]  commit_n,
   output logic             flush
);
   logic go;

   always_comb begin
      go       = 1'b1;
      commit_n = '0;
      flush    = 1'b0;
      for (int k = 0; k < int'(RETIRE_W); k++) begin
         rt_en[k] = go && (k < int'(used)) && rd_valid[k] && rd_done[k];
         if (rt_en[k]) begin
            commit_n = commit_n + 1'b1;
            if ((rd_op[k] == OP_BRANCH) && rd_mp[k]) begin
               flush = 1'b1;
               go    = 1'b0;
            end
         end else begin
            go = 1'b0;
         end
      end
   end
endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH    = 40,
   parameter int unsigned ALLOC_W  = 6,
   parameter int unsigned RETIRE_W = 3,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned AREG_W   = 5,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned AN_W  = $clog2(ALLOC_W + 1),
   localparam int unsigned RN_W  = $clog2(RETIRE_W + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [AN_W-1:0]              alloc_cnt,
   input  logic [2*ALLOC_W-1:0]         alloc_op,
   input  logic [2*ALLOC_W-1:0]         alloc_dst,
   input  logic [AREG_W*ALLOC_W-1:0]    alloc_areg,
   output logic                         alloc_ready,
   output logic [IDX_W*ALLOC_W-1:0]     alloc_tag,
   input  logic                         wb_valid,
   input  logic [IDX_W-1:0]             wb_tag,
   input  logic [DATA_W-1:0]            wb_value,
   input  logic                         wb_mispredict,
   output logic [RETIRE_W-1:0]          cm_valid,
   output logic [RETIRE_W-1:0]          cm_reg_we,
   output logic [RETIRE_W-1:0]          cm_store,
   output logic [AREG_W*RETIRE_W-1:0]   cm_areg,
   output logic [DATA_W*RETIRE_W-1:0]   cm_value,
   output logic [IDX_W*RETIRE_W-1:0]    cm_tag,
   output logic                         flush_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("rob_core: DEPTH must be at least 2");
   end
   if (ALLOC_W < 1 || ALLOC_W >= DEPTH) begin : g_bad_alloc
      $error("rob_core: ALLOC_W must lie in 1..DEPTH-1");
   end
   if (RETIRE_W < 1 || RETIRE_W > DEPTH) begin : g_bad_retire
      $error("rob_core: RETIRE_W must lie in 1..DEPTH");
   end

   logic [IDX_W-1:0]  head_idx, tail_idx;
   logic [CNT_W-1:0]  used, free_cnt;
   logic [AN_W-1:0]   alloc_n;
   logic [RN_W-1:0]   commit_n;
   logic              flush, alloc_go;

   logic              al_we   [ALLOC_W];
   logic [IDX_W-1:0]  al_idx  [ALLOC_W];
   op_kind_e          al_op   [ALLOC_W];
   dst_kind_e         al_dst  [ALLOC_W];
   logic [AREG_W-1:0] al_areg [ALLOC_W];

   logic              rt_en   [RETIRE_W];
   logic [IDX_W-1:0]  rd_idx  [RETIRE_W];
   logic              rd_valid[RETIRE_W];
   logic              rd_done [RETIRE_W];
   logic              rd_mp   [RETIRE_W];
   op_kind_e          rd_op   [RETIRE_W];
   dst_kind_e         rd_dst  [RETIRE_W];
   logic [AREG_W-1:0] rd_areg [RETIRE_W];
   logic [DATA_W-1:0] rd_value[RETIRE_W];

   assign alloc_ready = (32'(alloc_cnt) <= ALLOC_W) && (32'(alloc_cnt) <= 32'(free_cnt)) && !flush;
   assign alloc_go    = alloc_ready && (alloc_cnt != '0);
   assign alloc_n     = alloc_go ? alloc_cnt : '0;

   for (genvar j = 0; j < int'(ALLOC_W); j++) begin : g_alloc_lane
      assign al_idx[j]  = IDX_W'(wrap_add(32'(tail_idx), j, DEPTH));
      assign al_we[j]   = alloc_go && (j < int'(alloc_cnt));
      assign al_op[j]   = op_kind_e'(alloc_op[2*j +: 2]);
      assign al_dst[j]  = dst_kind_e'(alloc_dst[2*j +: 2]);
      assign al_areg[j] = alloc_areg[AREG_W*j +: AREG_W];
      assign alloc_tag[IDX_W*j +: IDX_W] = al_idx[j];
   end

   for (genvar k = 0; k < int'(RETIRE_W); k++) begin : g_commit_lane
      assign rd_idx[k]    = IDX_W'(wrap_add(32'(head_idx), k, DEPTH));
      assign cm_valid[k]  = rt_en[k];
      assign cm_reg_we[k] = rt_en[k] && (rd_dst[k] == DK_REG);
      assign cm_store[k]  = rt_en[k] && (rd_dst[k] == DK_MEM);
      assign cm_areg[AREG_W*k +: AREG_W] = rd_areg[k];
      assign cm_value[DATA_W*k +: DATA_W] = rd_value[k];
      assign cm_tag[IDX_W*k +: IDX_W]     = rd_idx[k];
   end

   assign flush_o = flush;

   rob_ptr_ctrl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RETIRE_W(RETIRE_W)) i_ptr (
      .clk(clk), .rst_n(rst_n), .alloc_n(alloc_n), .commit_n(commit_n), .flush(flush),
      .head_idx(head_idx), .tail_idx(tail_idx), .used_o(used), .free_o(free_cnt));

   rob_entry_array #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RETIRE_W(RETIRE_W),
                     .DATA_W(DATA_W), .AREG_W(AREG_W)) i_slots (
      .clk(clk), .rst_n(rst_n),
      .al_we(al_we), .al_idx(al_idx), .al_op(al_op), .al_dst(al_dst), .al_areg(al_areg),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mp(wb_mispredict),
      .flush(flush), .rt_en(rt_en), .rd_idx(rd_idx),
      .rd_valid(rd_valid), .rd_done(rd_done), .rd_mp(rd_mp), .rd_op(rd_op),
      .rd_dst(rd_dst), .rd_areg(rd_areg), .rd_value(rd_value));

   rob_retire_sel #(.DEPTH(DEPTH), .RETIRE_W(RETIRE_W)) i_sel (
      .used(used), .rd_valid(rd_valid), .rd_done(rd_done), .rd_mp(rd_mp), .rd_op(rd_op),
      .rt_en(rt_en), .commit_n(commit_n), .flush(flush));

   // R8
   flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o);
endmodule

// File: tb/test_rob_core.sv
module test_rob_core;
   localparam int DEPTH = 40, AW = 6, RW = 3, DW = 32, ARW = 5, IW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      alloc_cnt = '0;
   logic [2*AW-1:0] alloc_op = '0, alloc_dst = '0;
   logic [ARW*AW-1:0] alloc_areg = '0;
   logic            alloc_ready;
   logic [IW*AW-1:0] alloc_tag;
   logic            wb_valid = 1'b0, wb_mispredict = 1'b0;
   logic [IW-1:0]   wb_tag = '0;
   logic [DW-1:0]   wb_value = '0;
   logic [RW-1:0]   cm_valid, cm_reg_we, cm_store;
   logic [ARW*RW-1:0] cm_areg;
   logic [DW*RW-1:0]  cm_value;
   logic [IW*RW-1:0]  cm_tag;
   logic            flush_o;

   int n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   rob_core i_rob_core (
      .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_op(alloc_op),
      .alloc_dst(alloc_dst), .alloc_areg(alloc_areg), .alloc_ready(alloc_ready),
      .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .wb_mispredict(wb_mispredict), .cm_valid(cm_valid), .cm_reg_we(cm_reg_we),
      .cm_store(cm_store), .cm_areg(cm_areg), .cm_value(cm_value), .cm_tag(cm_tag),
      .flush_o(flush_o));

   task automatic chk(string req, string what, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_lane(int j, int op, int dst, int areg);
      alloc_op[2*j +: 2]       = 2'(op);
      alloc_dst[2*j +: 2]      = 2'(dst);
      alloc_areg[ARW*j +: ARW] = ARW'(areg);
   endtask

   task automatic do_alloc(string req, int n, bit exp_rdy, int first);
      alloc_cnt = 3'(n);
      #1;
      chk(req, "alloc_ready", alloc_ready, exp_rdy);
      if (exp_rdy)
         for (int j = 0; j < n; j++)
            chk(req, "alloc_tag", alloc_tag[IW*j +: IW], (first + j) % DEPTH);
      @(negedge clk);
      alloc_cnt = '0;
      #1;
   endtask

   task automatic do_wb(int tag, int val, bit mp);
      wb_valid = 1'b1; wb_tag = IW'(tag); wb_value = DW'(val); wb_mispredict = mp;
      @(negedge clk);
      wb_valid = 1'b0; wb_mispredict = 1'b0;
      #1;
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic lane_chk(string req, int k, bit v, int tag, bit rw, bit st, int val);
      chk(req, $sformatf("cm_valid[%0d]", k), cm_valid[k], v);
      if (v) begin
         chk(req, $sformatf("cm_tag[%0d]", k), cm_tag[IW*k +: IW], tag);
         chk(req, $sformatf("cm_reg_we[%0d]", k), cm_reg_we[k], rw);
         chk(req, $sformatf("cm_store[%0d]", k), cm_store[k], st);
         chk(req, $sformatf("cm_value[%0d]", k), cm_value[DW*k +: DW], val);
      end
   endtask

   task automatic ready_probe(string req, int n, bit exp);
      alloc_cnt = 3'(n);
      #1;
      chk(req, $sformatf("alloc_ready for %0d", n), alloc_ready, exp);
      alloc_cnt = '0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1", "cm_valid", cm_valid, 0);
      chk("R1", "flush_o", flush_o, 0);
      ready_probe("R1", AW, 1'b1);
   endtask

   task automatic t_in_order();
      // tags 0..5: reg, store, branch, reg, reg, store
      set_lane(0, 0, 1, 1); set_lane(1, 1, 2, 0); set_lane(2, 2, 0, 0);
      set_lane(3, 0, 1, 4); set_lane(4, 0, 1, 5); set_lane(5, 1, 2, 0);
      do_alloc("R2", 6, 1'b1, 0);
      for (int j = 0; j < AW; j++) set_lane(j, 0, 1, 6 + j);
      do_alloc("R2", 3, 1'b1, 6);
      do_wb(1, 'h101, 1'b0);
      chk("R5", "younger done waits", cm_valid, 0);
      do_wb(0, 'h100, 1'b0);
      lane_chk("R6", 0, 1'b1, 0, 1'b1, 1'b0, 'h100);
      chk("R6", "cm_areg[0]", cm_areg[ARW-1:0], 1);
      lane_chk("R6", 1, 1'b1, 1, 1'b0, 1'b1, 'h101);
      lane_chk("R5", 2, 1'b0, 0, 1'b0, 1'b0, 0);
      do_wb(3, 'h103, 1'b0);
      chk("R5", "blocked by tag 2", cm_valid, 0);
      do_wb(4, 'h104, 1'b0);
      do_wb(5, 'h105, 1'b0);
      do_wb(2, 'h102, 1'b0);
      // R9: branch without mispredict drains normally, no register or store
      lane_chk("R9", 0, 1'b1, 2, 1'b0, 1'b0, 'h102);
      chk("R9", "flush_o", flush_o, 0);
      lane_chk("R5", 1, 1'b1, 3, 1'b1, 1'b0, 'h103);
      lane_chk("R5", 2, 1'b1, 4, 1'b1, 1'b0, 'h104);
      tick();
      lane_chk("R5", 0, 1'b1, 5, 1'b0, 1'b1, 'h105);
      lane_chk("R5", 1, 1'b0, 0, 1'b0, 1'b0, 0);
      do_wb(6, 'h106, 1'b0);
      lane_chk("R5", 0, 1'b1, 6, 1'b1, 1'b0, 'h106);
      do_wb(7, 'h107, 1'b0);
      do_wb(8, 'h108, 1'b0);
      tick();
      chk("R5", "drained", cm_valid, 0);
   endtask

   task automatic t_ghost_write();
      do_wb(9, 'hDEAD, 1'b0);
      for (int j = 0; j < AW; j++) set_lane(j, 0, 1, j);
      do_alloc("R2", 2, 1'b1, 9);
      tick();
      chk("R4", "write to free slot ignored", cm_valid, 0);
      do_wb(9, 'h209, 1'b0);
      lane_chk("R4", 0, 1'b1, 9, 1'b1, 1'b0, 'h209);
      do_wb(10, 'h20A, 1'b0);
      lane_chk("R4", 0, 1'b1, 10, 1'b1, 1'b0, 'h20A);
      tick();
   endtask

   task automatic t_fill_flush();
      set_lane(1, 2, 0, 0);
      do_alloc("R2", 6, 1'b1, 11);
      set_lane(1, 0, 1, 1);
      do_alloc("R2", 6, 1'b1, 17);
      do_alloc("R2", 6, 1'b1, 23);
      do_alloc("R2", 6, 1'b1, 29);
      do_alloc("R2", 6, 1'b1, 35);
      do_alloc("R2", 6, 1'b1, 1);
      do_alloc("R2", 6, 1'b0, 7);
      do_alloc("R2", 4, 1'b1, 7);
      ready_probe("R3", 1, 1'b0);
      ready_probe("R3", 0, 1'b1);
      do_wb(11, 'h30B, 1'b0);
      lane_chk("R7", 0, 1'b1, 11, 1'b1, 1'b0, 'h30B);
      ready_probe("R7", 1, 1'b0);
      tick();
      ready_probe("R7", 1, 1'b1);
      ready_probe("R7", 2, 1'b0);
      do_wb(13, 'h30D, 1'b0);
      chk("R8", "branch not yet done", cm_valid, 0);
      do_wb(12, 'h30C, 1'b1);
      lane_chk("R8", 0, 1'b1, 12, 1'b0, 1'b0, 'h30C);
      chk("R8", "flush_o", flush_o, 1);
      chk("R8", "lane after branch", cm_valid[1], 0);
      ready_probe("R10", 1, 1'b0);
      tick();
      chk("R8", "younger discarded", cm_valid, 0);
      ready_probe("R8", AW, 1'b1);
      set_lane(0, 2, 0, 0); set_lane(1, 0, 1, 7);
      do_alloc("R8", 2, 1'b1, 13);
      do_wb(14, 'h40E, 1'b1);
      chk("R9", "head incomplete", cm_valid, 0);
      do_wb(13, 'h40D, 1'b0);
      lane_chk("R9", 0, 1'b1, 13, 1'b0, 1'b0, 'h40D);
      lane_chk("R9", 1, 1'b1, 14, 1'b1, 1'b0, 'h40E);
      chk("R9", "no flush from non-branch mark", flush_o, 0);
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_in_order();
      t_ghost_write();
      t_fill_flush();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule